// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a single-lane SPI master that runs one serial-flash command per request. A request names the command and the target chip select, and for some commands also an address and a byte count. The engine frames the opcode, the address bytes, the dummy byte and the data bytes, then frees the selected chip select. Data to be written is taken from a streaming input, one byte per `wr_ready` pulse. Data read back appears on a streaming output, one byte per `rd_valid` pulse.

The serial clock comes from an integer division of the core clock. The divisor is captured when a request is accepted. The bus runs in SPI mode 0. Before `done` pulses and a new request can be accepted, the chip selects stay released for a minimum number of core cycles. A page-program request that is too long, or that would wrap inside a page, is refused with a one-cycle `err` pulse and is never started.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, `cs_n` is all ones, `sck` is 0, and `busy`, `done`, `err`, `rd_valid` and `wr_ready` are all 0.
- R2: Let N be `div_n`, with values below 5 used as 5. Inside a command, every `sck` high phase lasts floor(N/2) core cycles and every low phase lasts N minus floor(N/2) core cycles. The first low phase starts in the cycle the chip select falls.
- R3: SPI mode 0. `sck` is low whenever no chip select is asserted. `mosi` changes only while `sck` is low, and every byte is sent MSB first.
- R4: Exactly the chip select `cs_n[req_cs]` is driven low for a command, and no two chip selects are ever low together.
- R5: `req_op` encoding: 0 fast read, 1 page program, 2 sector erase, 3 chip erase, 4 write enable, 5 read status, 6 write status. The opcode bytes are 0x0B, 0x02, 0x20, 0xC7, 0x06, 0x05 and 0x01. Fast read, page program and sector erase follow the opcode with the three bytes of `req_addr`, most significant byte first.
- R6: A fast read sends one 0x00 dummy byte after the address, then clocks `req_len` data bytes while `mosi` stays 0. Each received byte is presented on `rd_data` with a one-cycle `rd_valid`, in order.
- R7: Page program sends `req_len` data bytes after the address, and write status sends exactly one data byte after the opcode. Each data byte is taken from `wr_data` in the cycle `wr_ready` is high.
- R8: A request is refused when the opcode value is 7, or when it is a page program with `req_len` equal to 0 or `req_addr[7:0] + req_len > 256`. A refused request gives `err` high in the cycle after acceptance, leaves `busy` low and asserts no chip select. A program of exactly 256 bytes from a page start is accepted.
- R9: After a command, all chip selects stay high for at least `CSH_CYC` core cycles before any chip select falls again. `done` pulses for one cycle when that gap has elapsed, and `busy` is low from then on.
- R10: A request presented while `busy` is high is ignored.
- R11: Read status clocks exactly one byte after the opcode and returns it on `rd_data` with `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | Command selector |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Data byte count for read and program |
| req_cs | input | CS_W | Chip select index |
| div_n | input | DIV_W | Serial clock divisor |
| wr_data | input | 8 | Byte to be sent on the next `wr_ready` |
| wr_ready | output | 1 | `wr_data` is consumed in this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` is valid in this cycle |
| busy | output | 1 | A command or the release gap is in progress |
| done | output | 1 | One-cycle pulse when a command has finished |
| err | output | 1 | One-cycle pulse when a request is refused |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| cs_n | output | NCS | Active-low chip selects |
| miso | input | 1 | Serial data from flash |

## Verification
The case that is hardest to reach is a new command that follows the previous one as early as possible. The bench issues the second request in the same cycle it sees `done`, so the measured chip-select gap is the smallest the engine allows. A second hard case is a foreign request that arrives mid-transfer, aimed at the other chip select. The bench injects it while a read is still clocking and then checks that only the first chip select was ever driven. A flash model in the bench decodes the captured bytes and returns address-dependent data. This lets the bench check a fast read whose address wraps at the top of the 24-bit space, and a full 256-byte page program.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [2:0] {
    OP_FREAD  = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_WREN   = 3'd4,
    OP_RDSR   = 3'd5,
    OP_WRSR   = 3'd6
  } op_e;

  function automatic logic [7:0] op_code(op_e o);
    case (o)
      OP_FREAD:  return 8'h0B;
      OP_PROG:   return 8'h02;
      OP_SERASE: return 8'h20;
      OP_CERASE: return 8'hC7;
      OP_WREN:   return 8'h06;
      OP_RDSR:   return 8'h05;
      OP_WRSR:   return 8'h01;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic has_addr(op_e o);
    return (o == OP_FREAD) || (o == OP_PROG) || (o == OP_SERASE);
  endfunction

  function automatic logic op_reads(op_e o);
    return (o == OP_FREAD) || (o == OP_RDSR);
  endfunction

  function automatic logic op_writes(op_e o);
    return (o == OP_PROG) || (o == OP_WRSR);
  endfunction
endpackage

// File: rtl/sfe_div.sv
module sfe_div #(
  parameter int DIV_W   = 7,
  parameter int DIV_MIN = 5
) (
  input  logic [DIV_W-1:0] div_n,
  output logic [DIV_W-1:0] hi_len,
  output logic [DIV_W-1:0] lo_len
);
  logic [DIV_W-1:0] n_eff;

  always_comb begin
    n_eff  = (div_n < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_n;
    hi_len = n_eff >> 1;
    lo_len = n_eff - hi_len;
  end
endmodule

// File: rtl/sfe_bitio.sv
module sfe_bitio #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] hi_len,
  input  logic [DIV_W-1:0] lo_len,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             last_edge,
  output logic [7:0]       rx_byte
);
  logic             active, phase_hi;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  assign last_edge = active && phase_hi && (cnt == hi_len - DIV_W'(1)) && (bitn == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      rx_byte  <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      phase_hi <= 1'b0;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= tx_byte;
      mosi     <= tx_byte[7];
      sck      <= 1'b0;
    end else if (active) begin
      if (!phase_hi) begin
        if (cnt == lo_len - DIV_W'(1)) begin
          sck      <= 1'b1;
          phase_hi <= 1'b1;
          cnt      <= '0;
          rx_byte  <= {rx_byte[6:0], miso};
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end else if (cnt == hi_len - DIV_W'(1)) begin
        sck      <= 1'b0;
        phase_hi <= 1'b0;
        cnt      <= '0;
        if (bitn == 3'd7) begin
          active <= 1'b0;
        end else begin
          bitn <= bitn + 3'd1;
          sh   <= {sh[6:0], 1'b0};
          mosi <= sh[6];
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfe_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int DIV_W   = 7,
  parameter int DIV_MIN = 5,
  parameter int NCS     = 2,
  parameter int CSH_CYC = 40,
  parameter int PAGE    = 256,
  localparam int CS_W   = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [CS_W-1:0]  req_cs,
  input  logic [DIV_W-1:0] div_n,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             sck,
  output logic             mosi,
  output logic [NCS-1:0]   cs_n,
  input  logic             miso
);
  localparam int IDX_W  = LEN_W + 1;
  localparam int PAGE_W = $clog2(PAGE);
  localparam int G_W    = $clog2(CSH_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_e;

  st_e              st;
  op_e              op_q;
  logic [23:0]      addr_q;
  logic [DIV_W-1:0] div_q, hi_len, lo_len;
  logic [IDX_W-1:0] idx, total, hdr, nxt_idx;
  logic [IDX_W-1:0] r_hdr, r_total;
  logic [G_W-1:0]   gcnt;
  logic [LEN_W:0]   page_end;
  logic [7:0]       nxt_byte, eng_tx, rx_byte;
  logic             req_bad, accept, more, last_edge, eng_start;
  op_e              r_op;

  // Request decode
  always_comb begin
    r_op     = op_e'(req_op);
    page_end = (LEN_W+1)'(req_addr[PAGE_W-1:0]) + (LEN_W+1)'(req_len);
    req_bad  = (req_op > 3'd6) ||
               ((r_op == OP_PROG) && ((req_len == '0) || (page_end > (LEN_W+1)'(PAGE))));
    r_hdr    = IDX_W'(1) + (has_addr(r_op) ? IDX_W'(3) : '0) +
               ((r_op == OP_FREAD) ? IDX_W'(1) : '0);
    if ((r_op == OP_FREAD) || (r_op == OP_PROG))    r_total = r_hdr + IDX_W'(req_len);
    else if ((r_op == OP_RDSR) || (r_op == OP_WRSR)) r_total = r_hdr + IDX_W'(1);
    else                                             r_total = r_hdr;
  end

  assign accept  = (st == S_IDLE) && req_valid && !req_bad;
  assign nxt_idx = idx + IDX_W'(1);
  assign more    = nxt_idx < total;

  // Next byte on the wire
  always_comb begin
    nxt_byte = 8'h00;
    if (nxt_idx < hdr) begin
      if (has_addr(op_q) && (nxt_idx <= IDX_W'(3))) begin
        case (nxt_idx[1:0])
          2'd1:    nxt_byte = addr_q[23:16];
          2'd2:    nxt_byte = addr_q[15:8];
          default: nxt_byte = addr_q[7:0];
        endcase
      end
    end else if (op_writes(op_q)) begin
      nxt_byte = wr_data;
    end
  end

  assign eng_tx    = (st == S_IDLE) ? op_code(r_op) : nxt_byte;
  assign eng_start = accept || (last_edge && more);
  assign wr_ready  = last_edge && more && (nxt_idx >= hdr) && op_writes(op_q);

  sfe_div #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_div (
    .div_n (div_q),
    .hi_len(hi_len),
    .lo_len(lo_len)
  );

  sfe_bitio #(.DIV_W(DIV_W)) u_bitio (
    .clk      (clk),
    .rst      (rst),
    .start    (eng_start),
    .tx_byte  (eng_tx),
    .hi_len   (hi_len),
    .lo_len   (lo_len),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .last_edge(last_edge),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_q     <= OP_WREN;
      addr_q   <= '0;
      div_q    <= DIV_W'(DIV_MIN);
      idx      <= '0;
      total    <= '0;
      hdr      <= '0;
      gcnt     <= '0;
      cs_n     <= '1;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_bad) begin
              err <= 1'b1;
            end else begin
              st     <= S_XFER;
              busy   <= 1'b1;
              cs_n   <= ~(NCS'(1) << req_cs);
              op_q   <= r_op;
              addr_q <= req_addr;
              div_q  <= div_n;
              idx    <= '0;
              total  <= r_total;
              hdr    <= r_hdr;
            end
          end
        end
        S_XFER: begin
          if (last_edge) begin
            rd_valid <= op_reads(op_q) && (idx >= hdr);
            rd_data  <= rx_byte;
            if (more) begin
              idx <= nxt_idx;
            end else begin
              cs_n <= '1;
              gcnt <= '0;
              st   <= S_GAP;
            end
          end
        end
        default: begin
          if (gcnt == G_W'(CSH_CYC - 1)) begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            gcnt <= gcnt + G_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk #(
  parameter int NCS     = 2,
  parameter int CSH_CYC = 40
) (
  input logic           clk,
  input logic           rst,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           rd_valid
);
  localparam int GW = $clog2(CSH_CYC + 2);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)           gap_q <= GW'(CSH_CYC);
    else if (!(&cs_n)) gap_q <= '0;
    else if (gap_q < GW'(CSH_CYC)) gap_q <= gap_q + GW'(1);
  end

  a_r4_one_cs: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (rst) (&cs_n) |-> !sck);
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (rst)
    ((&$past(cs_n)) && !(&cs_n)) |-> (gap_q >= GW'(CSH_CYC)));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && (&cs_n)));
  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst) err |-> (!busy && (&cs_n)));
  a_r6_rdv_busy: assert property (@(posedge clk) disable iff (rst) rd_valid |-> busy);
endmodule

bind sflash_cmd_engine sfe_chk #(.NCS(NCS), .CSH_CYC(CSH_CYC)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .busy(busy),
  .done(done), .err(err), .rd_valid(rd_valid)
);

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;
  localparam int CSH = 40;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd4;
  logic [23:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic req_cs = 1'b0;
  logic [6:0] div_n = 7'd5;
  logic [7:0] wr_data, rd_data;
  logic wr_ready, rd_valid, busy, done, err, sck, mosi, miso;
  logic [1:0] cs_n;

  int checks = 0, errors = 0;
  logic [7:0] cap [0:299];
  logic [7:0] rdb [0:299];
  logic [7:0] shreg;
  int nbits, nrd, wcnt, hi_min, hi_max, lo_min, lo_max, run, gapc, last_gap, viol;
  logic inc_pend, prev_lvl, pm;
  logic [1:0] cs_seen;
  wire cs_all = &cs_n;

  always #2.5 clk = ~clk;

  sflash_cmd_engine uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_len(req_len), .req_cs(req_cs), .div_n(div_n), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  function automatic logic [7:0] fdata(input logic [23:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'd7;
  endfunction
  function automatic logic [7:0] wbyte(input int k);
    return 8'(k * 7 + 3);
  endfunction

  assign wr_data = wbyte(wcnt);

  // flash model
  initial begin nbits = 0; miso = 1'b0; shreg = '0; end
  always @(negedge cs_all) nbits = 0;
  always @(posedge sck) if (!cs_all) begin
    shreg = {shreg[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0 && nbits <= 2400) cap[nbits/8 - 1] = shreg;
  end
  always @(negedge sck) if (!cs_all) begin
    int k;
    logic [7:0] v;
    k = nbits / 8;
    v = 8'h00;
    if (k >= 5 && cap[0] == 8'h0B) v = fdata({cap[1], cap[2], cap[3]} + 24'(k - 5));
    else if (k >= 1 && cap[0] == 8'h05) v = 8'hA3;
    miso = v[7 - nbits % 8];
  end

  // monitors
  initial begin
    nrd = 0; wcnt = 0; inc_pend = 0; run = 0; gapc = 0; last_gap = 1000; viol = 0;
    prev_lvl = 0; pm = 0; cs_seen = 0;
  end
  always @(negedge clk) begin
    if (inc_pend) wcnt++;
    inc_pend = wr_ready;
    if (rd_valid && nrd < 300) begin rdb[nrd] = rd_data; nrd++; end
    cs_seen = cs_seen | ~cs_n;
    if (cs_all) begin
      gapc++; run = 0;
    end else begin
      if (gapc > 0) last_gap = gapc;
      gapc = 0;
      if (sck && mosi != pm) viol++;
      if (run == 0) begin run = 1; prev_lvl = sck; end
      else if (sck == prev_lvl) run++;
      else begin
        if (prev_lvl) begin if (run < hi_min) hi_min = run; if (run > hi_max) hi_max = run; end
        else begin if (run < lo_min) lo_min = run; if (run > lo_max) lo_max = run; end
        prev_lvl = sck; run = 1;
      end
    end
    pm = mosi;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic got_err, got_done;
  task automatic run_cmd(input int op, input int cs, input logic [23:0] a, input int len, input int n);
    int t;
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
    nrd = 0; wcnt = 0; inc_pend = 0; cs_seen = 0;
    req_op = 3'(op); req_cs = cs[0]; req_addr = a; req_len = 12'(len); div_n = 7'(n);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_err = err; got_done = done; t = 0;
    while (!got_err && !got_done && t < 30000) begin
      @(negedge clk);
      got_err = err; got_done = done; t++;
    end
  endtask

  task automatic chk_frame(input string tag, input int op, input logic [23:0] a, input int len);
    int hdr, tot, bad;
    logic [7:0] e;
    logic [7:0] opc [0:6];
    opc = '{8'h0B, 8'h02, 8'h20, 8'hC7, 8'h06, 8'h05, 8'h01};
    hdr = (op <= 2) ? 4 : 1;
    if (op == 0) hdr = 5;
    tot = hdr + ((op <= 1) ? len : (op >= 5) ? 1 : 0);
    chk({tag, " byte count"}, nbits / 8, tot);
    bad = 0;
    for (int i = 0; i < tot && i < 300; i++) begin
      if (i == 0) e = opc[op];
      else if (i < 4 && hdr >= 4) e = (i == 1) ? a[23:16] : (i == 2) ? a[15:8] : a[7:0];
      else if (i < hdr) e = 8'h00;
      else if (op == 1 || op == 6) e = wbyte(i - hdr);
      else e = 8'h00;
      if (cap[i] !== e) begin
        bad++;
        if (bad == 1) $display("FAIL %s byte %0d actual=%h expected=%h", tag, i, cap[i], e);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n idle", int'(cs_n), 3);
    chk("R1 sck idle", int'(sck), 0);
    chk("R1 busy/done/err", int'({busy, done, err, rd_valid, wr_ready}), 0);

    // R2 divisor sweep, R5 write-enable framing
    for (int n = 3; n <= 12; n++) begin
      int ne;
      ne = (n < 5) ? 5 : n;
      run_cmd(4, 0, 24'h0, 0, n);
      chk($sformatf("R2 hi max n=%0d", n), hi_max, ne / 2);
      chk($sformatf("R2 hi min n=%0d", n), hi_min, ne / 2);
      chk($sformatf("R2 lo max n=%0d", n), lo_max, ne - ne / 2);
      chk($sformatf("R2 lo min n=%0d", n), lo_min, ne - ne / 2);
      chk_frame("R5 write enable", 4, 24'h0, 0);
    end

    // R6 fast read with address wrap
    run_cmd(0, 0, 24'hFFFFFD, 6, 5);
    chk_frame("R6 fast read frame", 0, 24'hFFFFFD, 6);
    chk("R6 read count", nrd, 6);
    for (int k = 0; k < 6; k++)
      chk($sformatf("R6 read byte %0d", k), int'(rdb[k]), int'(fdata(24'hFFFFFD + 24'(k))));
    chk("R4 cs0 only", int'(cs_seen), 1);

    // R7 page program on cs1, ending exactly at page end
    run_cmd(1, 1, 24'h0012FC, 4, 6);
    chk("R7 program accepted", int'(got_done), 1);
    chk_frame("R7 program frame", 1, 24'h0012FC, 4);
    chk("R4 cs1 only", int'(cs_seen), 2);

    run_cmd(2, 0, 24'h123456, 0, 5);
    chk_frame("R5 sector erase", 2, 24'h123456, 0);
    run_cmd(3, 1, 24'h0, 0, 5);
    chk_frame("R5 chip erase", 3, 24'h0, 0);
    run_cmd(5, 0, 24'h0, 0, 7);
    chk_frame("R11 read status frame", 5, 24'h0, 0);
    chk("R11 status count", nrd, 1);
    chk("R11 status value", int'(rdb[0]), 8'hA3);
    run_cmd(6, 0, 24'h0, 9, 5);
    chk_frame("R7 write status one byte", 6, 24'h0, 0);

    // R8 refusals
    run_cmd(1, 0, 24'h000100, 0, 5);
    chk("R8 len0 err", int'(got_err), 1);
    chk("R8 len0 no cs", int'(cs_seen), 0);
    chk("R8 len0 busy", int'(busy), 0);
    run_cmd(1, 0, 24'h000100, 257, 5);
    chk("R8 len257 err", int'(got_err), 1);
    run_cmd(1, 1, 24'h0012FD, 4, 5);
    chk("R8 crossing err", int'(got_err), 1);
    chk("R8 crossing no cs", int'(cs_seen), 0);
    run_cmd(7, 0, 24'h0, 0, 5);
    chk("R8 bad opcode err", int'(got_err), 1);
    run_cmd(1, 0, 24'h001200, 256, 5);
    chk("R8 full page accepted", int'(got_done), 1);
    chk_frame("R8 full page frame", 1, 24'h001200, 256);

    // R9 back-to-back: second request in the done cycle
    run_cmd(4, 0, 24'h0, 0, 5);
    run_cmd(4, 1, 24'h0, 0, 5);
    chk("R9 gap at least CSH", int'(last_gap >= CSH), 1);
    chk("R9 second done", int'(got_done), 1);
    chk("R9 busy after done", int'(busy), 0);

    // R10 request during busy is ignored
    hi_min = 1000; nrd = 0; cs_seen = 0;
    req_op = 3'd0; req_cs = 1'b0; req_addr = 24'h000040; req_len = 12'd3; div_n = 7'd5;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    req_op = 3'd3; req_cs = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int t;
      t = 0;
      while (!done && t < 30000) begin @(negedge clk); t++; end
    end
    chk("R10 only cs0 seen", int'(cs_seen), 1);
    chk_frame("R10 original frame kept", 0, 24'h000040, 3);
    chk("R10 read count", nrd, 3);
    repeat (5) @(negedge clk);
    chk("R10 stays idle", int'({busy, ~cs_n}), 0);

    chk("R3 mosi stable while sck high", viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule